// File: doc/BRIEF.md
# Packed floating-point class tester

The block inspects every element of a 512-bit vector and reports, one bit per element, whether that element belongs to any of a chosen set of IEEE-754 special categories. The elements are either 32-bit single-precision or 64-bit double-precision values. A length select limits the test to the low 128, 256 or 512 bits of the vector.

An 8-bit category select chooses which categories count as a hit. A lane's hit bit is the OR of its element's membership in every selected category. Two qualifiers are applied after the hit bits are formed. An optional write-mask clears result bits, and a scalar mode keeps only element 0.

The result is captured in a register together with a valid flag. A consumer reads it one clock after it presents the operands.

Top module: `fp_class_tester`

## Requirements
- R1: Each category-select bit names one category: bit 7 signalling NaN, bit 6 negative finite nonzero, bit 5 denormal, bit 4 negative infinity, bit 3 positive infinity, bit 2 negative zero, bit 1 positive zero, bit 0 quiet NaN. A lane's result bit is 1 when its element matches at least one selected category. With select 0x18, a lane is set for either infinity and stays clear for a NaN.
- R2: An element with the exponent all ones and the fraction MSB set is a quiet NaN. An element with the exponent all ones, the fraction MSB clear and a nonzero fraction is a signalling NaN. The sign has no effect on either category.
- R3: The negative category matches exactly the elements that have the sign bit set and are neither zero, infinity nor NaN. Negative denormals therefore match this category.
- R4: The denormal category matches an all-zero exponent with a nonzero fraction, of either sign. For example, single 0x006CE3EE and double 0x000730D67819E8D2 match. Zeros do not match this category.
- R5: When `dbl`=0, element i is vec[32i+31:32i]. When `dbl`=1, element i is vec[64i+63:64i]. Result bit i belongs to element i.
- R6: `len_sel` 0, 1 and 2 select 128, 256 and 512 bits, and code 3 acts as 512. This gives 4, 8 or 16 single lanes, or 2, 4 or 8 double lanes. Result bits at or above the active lane count are 0.
- R7: When `mask_en`=1, result bit i is 0 wherever `wmask[i]`=0. When `mask_en`=0, `wmask` has no effect.
- R8: When `scalar`=1, only element 0 is tested and result bits 15..1 are 0. Scalar mode combines with the write-mask.
- R9: `out_valid` equals the value `in_valid` had one clock earlier. `out_mask` takes the new result in that same cycle. When `in_valid` is 0, `out_mask` holds its value.
- R10: A synchronous reset drives `out_valid` and `out_mask` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present this cycle |
| vec | input | 512 | Packed elements, element 0 in the LSBs |
| dbl | input | 1 | 1 = double precision, 0 = single precision |
| len_sel | input | 2 | Vector length code |
| cat_sel | input | 8 | Category select |
| mask_en | input | 1 | Apply the write-mask |
| wmask | input | 16 | Write-mask, one bit per lane |
| scalar | input | 1 | Test element 0 only |
| out_valid | output | 1 | Result valid |
| out_mask | output | 16 | Result mask, bit i for element i |

## Verification
The write-mask and scalar mode can act on the same result, together with length truncation. A wrong order or a missing gate would show only when these three meet. The sweep drives every category select at every precision and length code in four qualifier modes: plain, masked, scalar, and masked with scalar. The mask pattern changes with the select, so bit 0 of the mask is both set and clear while scalar mode is on. Each result is judged lane by lane against a classifier in the bench that works from the exponent and fraction values. The inputs are directed special encodings and random bit patterns.

// File: rtl/fp_class_tester.sv
module fp_class_tester #(
  parameter int VEC_W   = 512,
  parameter int MIN_W   = 128,
  parameter int SP_EXP  = 8,
  parameter int SP_FRAC = 23,
  parameter int DP_EXP  = 11,
  parameter int DP_FRAC = 52,
  parameter int LEN_W   = 2,
  localparam int SP_W   = 1 + SP_EXP + SP_FRAC,
  localparam int LANES  = VEC_W / SP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] vec,
  input  logic             dbl,
  input  logic [LEN_W-1:0] len_sel,
  input  logic [7:0]       cat_sel,
  input  logic             mask_en,
  input  logic [LANES-1:0] wmask,
  input  logic             scalar,
  output logic             out_valid,
  output logic [LANES-1:0] out_mask
);
  localparam int DP_W     = 1 + DP_EXP + DP_FRAC;
  localparam int DP_LANES = VEC_W / DP_W;
  localparam int SP_BASE  = MIN_W / SP_W;
  localparam int DP_BASE  = MIN_W / DP_W;
  localparam int MAX_LEN  = $clog2(VEC_W / MIN_W);

  function automatic logic [7:0] classify(input logic s, input logic e1, input logic e0,
                                          input logic fz, input logic ftop);
    logic [7:0] c;
    c[0] = e1 & ftop;
    c[1] = e0 & fz & ~s;
    c[2] = e0 & fz & s;
    c[3] = e1 & fz & ~s;
    c[4] = e1 & fz & s;
    c[5] = e0 & ~fz;
    c[6] = s & ~e1 & ~(e0 & fz);
    c[7] = e1 & ~ftop & ~fz;
    return c;
  endfunction

  logic [LANES-1:0]    sp_hit, act, res, keep;
  logic [DP_LANES-1:0] dp_hit;
  logic [LEN_W-1:0]    len_eff;
  int                  lanes_n;

  for (genvar i = 0; i < LANES; i++) begin : g_sp
    logic [SP_W-1:0] w;
    logic [7:0]      c;
    assign w = vec[i*SP_W +: SP_W];
    assign c = classify(w[SP_W-1], &w[SP_W-2 -: SP_EXP], ~|w[SP_W-2 -: SP_EXP],
                        ~|w[SP_FRAC-1:0], w[SP_FRAC-1]);
    assign sp_hit[i] = |(c & cat_sel);
  end

  for (genvar i = 0; i < DP_LANES; i++) begin : g_dp
    logic [DP_W-1:0] w;
    logic [7:0]      c;
    assign w = vec[i*DP_W +: DP_W];
    assign c = classify(w[DP_W-1], &w[DP_W-2 -: DP_EXP], ~|w[DP_W-2 -: DP_EXP],
                        ~|w[DP_FRAC-1:0], w[DP_FRAC-1]);
    assign dp_hit[i] = |(c & cat_sel);
  end

  assign len_eff = (int'(len_sel) > MAX_LEN) ? LEN_W'(MAX_LEN) : len_sel;
  assign lanes_n = (dbl ? DP_BASE : SP_BASE) << len_eff;

  for (genvar i = 0; i < LANES; i++) begin : g_act
    assign act[i] = (i < lanes_n);
  end

  assign res  = dbl ? LANES'(dp_hit) : sp_hit;
  assign keep = act & (mask_en ? wmask : '1) & (scalar ? LANES'(1) : '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_mask <= res & keep;
    end
  end
endmodule

module fp_class_tester_chk #(
  parameter int LANES     = 16,
  parameter int MIN_LANES = 4,
  parameter int LEN_W     = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             dbl,
  input logic [LEN_W-1:0] len_sel,
  input logic             mask_en,
  input logic [LANES-1:0] wmask,
  input logic             scalar,
  input logic             out_valid,
  input logic [LANES-1:0] out_mask
);
  assert_valid_rise_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_low_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_mask));
  assert_wmask_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en) |=> ((out_mask & ~$past(wmask)) == '0));
  assert_scalar_only_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar) |=> (out_mask[LANES-1:1] == '0));
  assert_dbl_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dbl) |=> (out_mask[LANES-1:LANES/2] == '0));
  assert_short_len_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dbl && len_sel == '0) |=> (out_mask[LANES-1:MIN_LANES] == '0));
endmodule

bind fp_class_tester fp_class_tester_chk #(.LANES(LANES), .MIN_LANES(MIN_W / SP_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dbl(dbl), .len_sel(len_sel),
  .mask_en(mask_en), .wmask(wmask), .scalar(scalar),
  .out_valid(out_valid), .out_mask(out_mask)
);

// File: tb/tb_fp_class_tester.sv
module tb_fp_class_tester;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [511:0] vec = '0;
  logic         dbl = 1'b0;
  logic [1:0]   len_sel = 2'd0;
  logic [7:0]   cat_sel = 8'd0;
  logic         mask_en = 1'b0;
  logic [15:0]  wmask = '0;
  logic         scalar = 1'b0;
  logic         out_valid;
  logic [15:0]  out_mask;

  int checks = 0;
  int fails  = 0;
  logic [15:0] last_exp = '0;
  logic [511:0] dir_s, dir_d;

  always #5 clk = ~clk;

  fp_class_tester dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vec(vec), .dbl(dbl), .len_sel(len_sel),
    .cat_sel(cat_sel), .mask_en(mask_en), .wmask(wmask), .scalar(scalar),
    .out_valid(out_valid), .out_mask(out_mask)
  );

  function automatic logic [7:0] ref_cat(bit s, longint unsigned e, longint unsigned emax,
                                         longint unsigned f, longint unsigned ftopv);
    logic [7:0] c = '0;
    bit isnan = (e == emax) && (f != 0);
    if (isnan && f >= ftopv) c[0] = 1;
    if (isnan && f < ftopv)  c[7] = 1;
    if (e == 0 && f == 0) c[s ? 2 : 1] = 1;
    if (e == emax && f == 0) c[s ? 4 : 3] = 1;
    if (e == 0 && f != 0) c[5] = 1;
    if (s && e != emax && !(e == 0 && f == 0)) c[6] = 1;
    return c;
  endfunction

  function automatic logic [15:0] expect_mask(logic [511:0] v, bit d, int len, logic [7:0] sel,
                                              bit men, logic [15:0] wm, bit sc);
    logic [15:0] r = '0;
    int n = (d ? 2 : 4) * (1 << ((len > 2) ? 2 : len));
    for (int i = 0; i < n; i++) begin
      logic [7:0] c;
      if (d) begin
        longint unsigned b = v[64*i +: 64];
        c = ref_cat(b[63], (b / 64'h0010_0000_0000_0000) % 2048, 2047,
                    b % 64'h0010_0000_0000_0000, 64'h0008_0000_0000_0000);
      end else begin
        longint unsigned b = {32'd0, v[32*i +: 32]};
        c = ref_cat(b[31], (b / 64'h80_0000) % 256, 255, b % 64'h80_0000, 64'h40_0000);
      end
      r[i] = ((c & sel) != 0);
      if (men && !wm[i]) r[i] = 0;
      if (sc && i > 0) r[i] = 0;
    end
    return r;
  endfunction

  task automatic check(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(string tag, logic [511:0] v, bit d, int len, logic [7:0] sel,
                      bit men, logic [15:0] wm, bit sc);
    logic [15:0] e = expect_mask(v, d, len, sel, men, wm, sc);
    vec = v; dbl = d; len_sel = 2'(len); cat_sel = sel;
    mask_en = men; wmask = wm; scalar = sc; in_valid = 1'b1;
    @(negedge clk);
    check(tag, out_valid === 1'b1 && out_mask === e, {15'd0, out_valid, out_mask}, {15'd0, 1'b1, e});
    last_exp = e;
    in_valid = 1'b0;
  endtask

  function automatic logic [511:0] rnd_vec();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    dir_s = {32'h00000001, 32'h7fffffff, 32'h00800000, 32'h007fffff,
             32'hff800001, 32'hffc00000, 32'hc0000000, 32'h3f800000,
             32'h806ce3ee, 32'h006ce3ee, 32'h7f800001, 32'h7fc00000,
             32'hff800000, 32'h7f800000, 32'h80000000, 32'h00000000};
    dir_d = {64'hbff0000000000000, 64'h000730d67819e8d2, 64'h7ff0000000000001,
             64'h7ff8000000000000, 64'hfff0000000000000, 64'h7ff0000000000000,
             64'h8000000000000000, 64'h0000000000000000};

    // R10: reset clears output even with operands presented
    in_valid = 1'b1; vec = dir_s; cat_sel = 8'hff; len_sel = 2'd2;
    repeat (3) @(negedge clk);
    check("R10", out_valid === 1'b0 && out_mask === 16'h0, {15'd0, out_valid, out_mask}, 32'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R10", out_valid === 1'b0 && out_mask === 16'h0, {15'd0, out_valid, out_mask}, 32'd0);

    xact("R1", dir_s, 0, 2, 8'h18, 0, 16'h0, 0);
    xact("R1", dir_d, 1, 2, 8'h06, 0, 16'h0, 0);
    xact("R2", dir_s, 0, 2, 8'h01, 0, 16'h0, 0);
    xact("R2", dir_s, 0, 2, 8'h80, 0, 16'h0, 0);
    xact("R2", dir_d, 1, 2, 8'h81, 0, 16'h0, 0);
    xact("R3", dir_s, 0, 2, 8'h40, 0, 16'h0, 0);
    xact("R3", dir_d, 1, 2, 8'h40, 0, 16'h0, 0);
    xact("R4", dir_s, 0, 2, 8'h20, 0, 16'h0, 0);
    xact("R4", dir_d, 1, 2, 8'h20, 0, 16'h0, 0);
    xact("R5", dir_d, 1, 2, 8'hff, 0, 16'h0, 0);
    xact("R5", dir_s, 0, 2, 8'hff, 0, 16'h0, 0);
    xact("R6", dir_s, 0, 0, 8'hff, 0, 16'h0, 0);
    xact("R6", dir_s, 0, 3, 8'hff, 0, 16'h0, 0);
    xact("R6", dir_d, 1, 1, 8'hff, 0, 16'h0, 0);
    xact("R7", dir_s, 0, 2, 8'hff, 1, 16'h5a3c, 0);
    xact("R7", dir_s, 0, 2, 8'hff, 0, 16'h0000, 0);
    xact("R8", dir_s, 0, 2, 8'h02, 0, 16'h0, 1);
    xact("R8", dir_s, 0, 2, 8'h02, 1, 16'hfffe, 1);

    // R9: idle cycle keeps result, drops valid
    vec = rnd_vec(); cat_sel = ~cat_sel; wmask = ~wmask;
    @(negedge clk);
    check("R9", out_valid === 1'b0 && out_mask === last_exp, {15'd0, out_valid, out_mask}, {16'd0, last_exp});

    for (int sel = 0; sel < 256; sel++)
      for (int d = 0; d < 2; d++)
        for (int len = 0; len < 4; len++)
          for (int mode = 0; mode < 4; mode++) begin
            logic [511:0] v = (sel % 3 == 0) ? rnd_vec() : (d ? dir_d : dir_s);
            logic [15:0] wm = {8'(sel), ~8'(sel)} ^ 16'ha5c3 ^ 16'(mode);
            xact("R1", v, d[0], len, 8'(sel), mode[0], wm, mode[1]);
          end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule